// File: doc/BRIEF.md
# Packed Four-Slot Instruction Sequencer

This block drives the front end of a small 18-bit stack processor. It fetches one instruction word at a time, then hands the opcodes packed inside that word to the execution datapath, one opcode per clock. A word holds up to four 5-bit opcodes. The last slot is only 3 bits wide, so only opcodes whose two low bits are zero can sit there. The sequencer owns the 10-bit program counter and its increment rules. It resolves jump, call, return, loop and conditional opcodes itself. Those decisions use the values of the top-of-stack (T) and loop-counter (R) registers, which it receives as inputs. It signals the changes it needs to R and the return stack as single-cycle strobes.

Stored words are kept in a scrambled form. The sequencer undoes the scrambling on the opcode fields only. An address field that follows a jump-class opcode is taken raw. The reach of a jump depends on the slot it occupies. A short loop can repeat the current word without a new fetch. The arithmetic opcodes and the memory itself live outside this block.

Top module: `isq_sequencer`

## Requirements
- R1: After reset the block requests a fetch at the reset address (default 0x0AA), and no opcode is issued until a word has been accepted.
- R2: Opcode fields are descrambled by XOR with 0x15555: slot 0 is bits 17..13, slot 1 is bits 12..8, slot 2 is bits 7..3, and slot 3 is bits 2..0 followed by two zero bits. One opcode is issued per cycle, together with its slot index 0..3.
- R3: On each accepted fetch, P advances only in its low 7 bits, so 0x03F goes to 0x040 and 0x07F wraps to 0x000; bits 8 and 9 never change. When bit 8 of P is set, P does not advance at all.
- R4: fetch_req stays high with a stable fetch_addr while fetch_ready is low. The cycle after fetch_ready is sampled high, slot 0 of the new word is issued.
- R5: A jump target replaces the low bits of the already-advanced P with the raw address field. In slot 0 the field is bits 9..0 and bits 12..10 are ignored. In slot 1 it is bits 7..0, and in slot 2 it is bits 2..0. Targets from slots 1 and 2 keep bit 9 of P and clear bit 8.
- R6: Opcode 0x00 loads P from R[9:0] and pops the return stack. Opcode 0x01 loads P from R[9:0] and swaps, writing the old P into R. Both drop the remaining slots and fetch the next word.
- R7: Opcode 0x04 with R = 0 pops the return stack and moves to the next slot, or fetches if it sits in slot 3. With R non-zero it decrements R and restarts at slot 0 of the same word, without a fetch.
- R8: Opcode 0x05 with R = 0 pops the return stack and fetches at P. With R non-zero it decrements R and jumps.
- R9: Opcode 0x06 jumps when T = 0, and opcode 0x07 jumps when T bit 17 is 0. When the condition fails, the next word is fetched at P.
- R10: Opcode 0x02 jumps. Opcode 0x03 pushes the advanced P onto the return stack (rs_push with r_wdata = P) and then jumps.
- R11: Every other opcode moves on to the next slot. After slot 3, the next word is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | output | 1 | A word is wanted from fetch_addr |
| fetch_addr | output | 10 | Current program counter |
| fetch_ready | input | 1 | fetch_word is valid this cycle |
| fetch_word | input | 18 | Stored (scrambled) instruction word |
| t_val | input | 18 | Current top-of-stack value |
| r_val | input | 18 | Current loop/return register value |
| op_valid | output | 1 | op_code and op_slot are being issued |
| op_code | output | 5 | Descrambled opcode |
| op_slot | output | 2 | Slot index of op_code |
| r_dec | output | 1 | Decrement R |
| rs_pop | output | 1 | Pop the return stack into R |
| rs_push | output | 1 | Push R onto the return stack, then load R from r_wdata |
| r_swap | output | 1 | Load R from r_wdata without stack motion |
| r_wdata | output | 10 | Value for R on push or swap (the program counter) |

## Verification
Several properties are checked on every cycle. A stalled fetch holds its address. An accepted word starts at slot 0. Slot 3 only ever carries opcodes whose low two bits are zero. At most one R/stack strobe fires per cycle. Plain opcodes step the slot by one, a loop with non-zero R restarts at slot 0, and a return fetches from the previous R.

Other behaviour only shows over a whole program, so the bench's scenarios cover it: jump targets built from each slot's field width, increment wrap at the region edges, the no-increment rule in I/O space, both outcomes of the conditional opcodes, and the scrambling of opcode fields.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int WORD_W   = 18;
  localparam int OP_W     = 5;
  localparam int SLOTS    = 4;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int TAIL_W   = WORD_W - (SLOTS - 1) * OP_W;
  localparam int PC_W     = 10;
  localparam int INC_W    = 7;
  localparam int IO_BIT   = 8;
  localparam int FIELD1_W = WORD_W - 2 * OP_W;
  localparam int FIELD2_W = TAIL_W;
  localparam logic [WORD_W-1:0] SCRAMBLE = 18'h15555;

  localparam logic [OP_W-1:0] OP_RET   = 5'h00;
  localparam logic [OP_W-1:0] OP_EXEC  = 5'h01;
  localparam logic [OP_W-1:0] OP_JUMP  = 5'h02;
  localparam logic [OP_W-1:0] OP_CALL  = 5'h03;
  localparam logic [OP_W-1:0] OP_UNEXT = 5'h04;
  localparam logic [OP_W-1:0] OP_NEXT  = 5'h05;
  localparam logic [OP_W-1:0] OP_IFZ   = 5'h06;
  localparam logic [OP_W-1:0] OP_IFP   = 5'h07;

  typedef enum logic {ST_FETCH = 1'b0, ST_EXEC = 1'b1} seq_state_e;
endpackage

// File: rtl/isq_slot_unpack.sv
module isq_slot_unpack
  import isq_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic [SLOT_W-1:0] slot,
  output logic [OP_W-1:0]   op
);
  logic [WORD_W-1:0] plain;
  logic [OP_W-1:0]   slot_ops [SLOTS];

  assign plain = raw ^ SCRAMBLE;

  genvar s;
  generate
    for (s = 0; s < SLOTS - 1; s++) begin : g_full
      assign slot_ops[s] = plain[WORD_W-1-OP_W*s -: OP_W];
    end
  endgenerate

  // last slot is narrow: its missing low bits are zero
  assign slot_ops[SLOTS-1] = {plain[TAIL_W-1:0], {(OP_W-TAIL_W){1'b0}}};

  assign op = slot_ops[slot];
endmodule

// File: rtl/isq_pc_calc.sv
module isq_pc_calc
  import isq_pkg::*;
(
  input  logic [PC_W-1:0]   p,
  input  logic [WORD_W-1:0] raw,
  input  logic [SLOT_W-1:0] slot,
  output logic [PC_W-1:0]   p_inc,
  output logic [PC_W-1:0]   dest
);
  always_comb begin
    p_inc = p;
    if (!p[IO_BIT]) begin
      p_inc[INC_W-1:0] = p[INC_W-1:0] + 1'b1;
    end
  end

  always_comb begin
    dest = p;
    case (slot)
      SLOT_W'(0): begin
        dest = raw[PC_W-1:0];
      end
      SLOT_W'(1): begin
        dest[FIELD1_W-1:0] = raw[FIELD1_W-1:0];
        dest[IO_BIT]       = 1'b0;
      end
      default: begin
        dest[FIELD2_W-1:0] = raw[FIELD2_W-1:0];
        dest[IO_BIT]       = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
  import isq_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC = 10'h0AA
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_req,
  output logic [PC_W-1:0]   fetch_addr,
  input  logic              fetch_ready,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic [WORD_W-1:0] t_val,
  input  logic [WORD_W-1:0] r_val,
  output logic              op_valid,
  output logic [OP_W-1:0]   op_code,
  output logic [SLOT_W-1:0] op_slot,
  output logic              r_dec,
  output logic              rs_pop,
  output logic              rs_push,
  output logic              r_swap,
  output logic [PC_W-1:0]   r_wdata
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [1:0]        rst_pipe;
  logic              rst_int;
  seq_state_e        state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [WORD_W-1:0] ir_q, ir_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              ir_en;
  logic [OP_W-1:0]   cur_op;
  logic [PC_W-1:0]   pc_inc, pc_dest;
  logic              r_zero, t_zero, t_pos;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  isq_slot_unpack u_unpack (
    .raw  (ir_q),
    .slot (slot_q),
    .op   (cur_op)
  );

  isq_pc_calc u_pc (
    .p     (pc_q),
    .raw   (ir_q),
    .slot  (slot_q),
    .p_inc (pc_inc),
    .dest  (pc_dest)
  );

  assign r_zero = (r_val == '0);
  assign t_zero = (t_val == '0);
  assign t_pos  = !t_val[WORD_W-1];

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    slot_d  = slot_q;
    ir_en   = 1'b0;
    r_dec   = 1'b0;
    rs_pop  = 1'b0;
    rs_push = 1'b0;
    r_swap  = 1'b0;
    r_wdata = pc_q;
    if (state_q == ST_FETCH) begin
      if (fetch_ready) begin
        ir_en   = 1'b1;
        ir_d    = fetch_word;
        pc_d    = pc_inc;
        slot_d  = '0;
        state_d = ST_EXEC;
      end
    end else begin
      case (cur_op)
        OP_RET: begin
          rs_pop  = 1'b1;
          pc_d    = r_val[PC_W-1:0];
          state_d = ST_FETCH;
        end
        OP_EXEC: begin
          r_swap  = 1'b1;
          pc_d    = r_val[PC_W-1:0];
          state_d = ST_FETCH;
        end
        OP_JUMP: begin
          pc_d    = pc_dest;
          state_d = ST_FETCH;
        end
        OP_CALL: begin
          rs_push = 1'b1;
          pc_d    = pc_dest;
          state_d = ST_FETCH;
        end
        OP_UNEXT: begin
          if (r_zero) begin
            rs_pop = 1'b1;
            if (slot_q == LAST_SLOT) state_d = ST_FETCH;
            else                     slot_d  = slot_q + 1'b1;
          end else begin
            r_dec  = 1'b1;
            slot_d = '0;
          end
        end
        OP_NEXT: begin
          state_d = ST_FETCH;
          if (r_zero) begin
            rs_pop = 1'b1;
          end else begin
            r_dec = 1'b1;
            pc_d  = pc_dest;
          end
        end
        OP_IFZ: begin
          state_d = ST_FETCH;
          if (t_zero) pc_d = pc_dest;
        end
        OP_IFP: begin
          state_d = ST_FETCH;
          if (t_pos) pc_d = pc_dest;
        end
        default: begin
          if (slot_q == LAST_SLOT) state_d = ST_FETCH;
          else                     slot_d  = slot_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)   ir_q <= '0;
    else if (ir_en) ir_q <= ir_d;
  end

  assign fetch_req  = (state_q == ST_FETCH);
  assign fetch_addr = pc_q;
  assign op_valid   = (state_q == ST_EXEC);
  assign op_code    = cur_op;
  assign op_slot    = slot_q;
endmodule

// File: rtl/isq_checker.sv
module isq_checker
  import isq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [PC_W-1:0]   fetch_addr,
  input logic              fetch_ready,
  input logic [WORD_W-1:0] r_val,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [SLOT_W-1:0] op_slot,
  input logic              r_dec,
  input logic              rs_pop,
  input logic              rs_push,
  input logic              r_swap
);
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ready |=> fetch_req && $stable(fetch_addr));

  p_accept_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_ready |=> op_valid && op_slot == '0);

  p_tail_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_slot == SLOT_W'(SLOTS - 1) |-> op_code[1:0] == 2'b00);

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({r_dec, rs_pop, rs_push, r_swap}));

  p_plain_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_slot != SLOT_W'(SLOTS - 1) && op_code[4:3] != 2'b00
    |=> op_valid && op_slot == $past(op_slot) + 1'b1);

  p_loop_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_UNEXT && r_val != '0 |=> op_valid && op_slot == '0);

  p_return_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_RET |=> fetch_req && fetch_addr == $past(r_val[PC_W-1:0]));

  p_call_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_CALL |=> fetch_req);
endmodule

bind isq_sequencer isq_checker u_isq_checker (
  .clk         (clk),
  .rst_n       (rst_int),
  .fetch_req   (fetch_req),
  .fetch_addr  (fetch_addr),
  .fetch_ready (fetch_ready),
  .r_val       (r_val),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .op_slot     (op_slot),
  .r_dec       (r_dec),
  .rs_pop      (rs_pop),
  .rs_push     (rs_push),
  .r_swap      (r_swap)
);

// File: tb/tb_isq_sequencer.sv
`timescale 1ns/1ps
module tb_isq_sequencer;
  localparam logic [17:0] SCR = 18'h15555;
  localparam logic [4:0] NOP = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, op_valid, r_dec, rs_pop, rs_push, r_swap;
  logic [9:0]  fetch_addr, r_wdata;
  logic        fetch_ready;
  logic [17:0] fetch_word, t_val, r_val;
  logic [4:0]  op_code;
  logic [1:0]  op_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [17:0] mem [0:1023];
  logic [17:0] rv;
  logic [17:0] rstk [$];

  // model state
  bit          m_fetch;
  logic [9:0]  m_p;
  logic [17:0] m_word;
  int          m_slot;

  always #2 clk = ~clk;

  isq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_word(fetch_word), .t_val(t_val),
    .r_val(r_val), .op_valid(op_valid), .op_code(op_code), .op_slot(op_slot),
    .r_dec(r_dec), .rs_pop(rs_pop), .rs_push(rs_push), .r_swap(r_swap),
    .r_wdata(r_wdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [17:0] w4(logic [4:0] a, logic [4:0] b, logic [4:0] c, logic [4:0] d);
    return {a, b, c, d[4:2]} ^ SCR;
  endfunction
  function automatic logic [17:0] wj0(logic [4:0] op, logic [9:0] ad);
    return (({op, 13'd0} ^ SCR) & 18'h3E000) | {8'd0, ad};
  endfunction
  function automatic logic [17:0] wj1(logic [4:0] a, logic [4:0] op, logic [7:0] ad);
    return (({a, op, 8'd0} ^ SCR) & 18'h3FF00) | {10'd0, ad};
  endfunction
  function automatic logic [17:0] wj2(logic [4:0] a, logic [4:0] b, logic [4:0] op, logic [2:0] ad);
    return (({a, b, op, 3'd0} ^ SCR) & 18'h3FFF8) | {15'd0, ad};
  endfunction

  function automatic logic [4:0] op_of(logic [17:0] w, int s);
    logic [17:0] pl = w ^ SCR;
    if (s < 3) return 5'((pl >> (13 - 5 * s)) & 18'h1F);
    return {pl[2:0], 2'b00};
  endfunction
  function automatic logic [9:0] adv(logic [9:0] p);
    if (p >= 10'h100 && p < 10'h200) return p;
    if (p >= 10'h300) return p;
    return (p & 10'h380) | ((p + 10'd1) & 10'h07F);
  endfunction
  function automatic logic [9:0] target(logic [17:0] w, int s, logic [9:0] p);
    if (s == 0) return w[9:0];
    if (s == 1) return (p & 10'h200) | {2'b00, w[7:0]};
    return (p & 10'h2F8) | {7'd0, w[2:0]};
  endfunction
  function automatic string tag_of(logic [4:0] op);
    case (op)
      5'h00, 5'h01: return "R6";
      5'h02, 5'h03: return "R10 R5";
      5'h04:        return "R7";
      5'h05:        return "R8";
      5'h06, 5'h07: return "R9";
      default:      return "R11";
    endcase
  endfunction

  task automatic step(input int cyc);
    bit          e_dec, e_pop, e_push, e_swap;
    logic [9:0]  e_wd;
    logic [4:0]  op;
    logic [9:0]  d;
    string       tg;
    fetch_ready = (cyc % 4) != 1;
    fetch_word  = mem[fetch_addr];
    case (cyc % 3)
      0:       t_val = 18'h00000;
      1:       t_val = 18'h20000;
      default: t_val = 18'h00005;
    endcase
    r_val = rv;
    #0.5;
    e_dec = 0; e_pop = 0; e_push = 0; e_swap = 0; e_wd = m_p;
    chk(fetch_req == m_fetch, "R3 R4 R5", "fetch_req", 32'(fetch_req), 32'(m_fetch));
    chk(op_valid == !m_fetch, "R4", "op_valid", 32'(op_valid), 32'(!m_fetch));
    tg = "R4";
    if (m_fetch) begin
      chk(fetch_addr == m_p, "R3 R5 R6", "fetch_addr", 32'(fetch_addr), 32'(m_p));
      if (fetch_ready) begin
        m_word = fetch_word; m_p = adv(m_p); m_slot = 0; m_fetch = 0;
      end
    end else begin
      op = op_of(m_word, m_slot);
      d  = target(m_word, m_slot, m_p);
      tg = tag_of(op);
      chk(op_code == op, "R2", "op_code", 32'(op_code), 32'(op));
      chk(op_slot == 2'(m_slot), "R2", "op_slot", 32'(op_slot), 32'(m_slot));
      case (op)
        5'h00: begin e_pop = 1; m_p = rv[9:0]; m_fetch = 1; end
        5'h01: begin e_swap = 1; m_p = rv[9:0]; m_fetch = 1; end
        5'h02: begin m_p = d; m_fetch = 1; end
        5'h03: begin e_push = 1; m_p = d; m_fetch = 1; end
        5'h04: begin
          if (rv == 0) begin
            e_pop = 1;
            if (m_slot == 3) m_fetch = 1; else m_slot++;
          end else begin e_dec = 1; m_slot = 0; end
        end
        5'h05: begin
          m_fetch = 1;
          if (rv == 0) e_pop = 1; else begin e_dec = 1; m_p = d; end
        end
        5'h06: begin m_fetch = 1; if (t_val == 0) m_p = d; end
        5'h07: begin m_fetch = 1; if (!t_val[17]) m_p = d; end
        default: begin if (m_slot == 3) m_fetch = 1; else m_slot++; end
      endcase
    end
    chk(r_dec == e_dec, tg, "r_dec", 32'(r_dec), 32'(e_dec));
    chk(rs_pop == e_pop, tg, "rs_pop", 32'(rs_pop), 32'(e_pop));
    chk(rs_push == e_push, tg, "rs_push", 32'(rs_push), 32'(e_push));
    chk(r_swap == e_swap, tg, "r_swap", 32'(r_swap), 32'(e_swap));
    if (e_push || e_swap)
      chk(r_wdata == e_wd, tg, "r_wdata", 32'(r_wdata), 32'(e_wd));
    // environment: R register and return stack
    if (e_dec) rv = rv - 18'd1;
    if (e_pop) rv = (rstk.size() > 0) ? rstk.pop_back() : 18'd0;
    if (e_push) begin rstk.push_back(rv); rv = {8'd0, e_wd}; end
    if (e_swap) rv = {8'd0, e_wd};
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = w4(NOP, NOP, NOP, NOP);
    mem[10'h0AA] = wj0(5'h05, 10'h0AA);                      // R8 counted loop
    mem[10'h0AB] = w4(5'h10, 5'h11, 5'h12, 5'h04);           // R2 slot 3 loop op
    mem[10'h0AC] = wj0(5'h02, 10'h03E);                      // R5 slot 0 jump
    mem[10'h040] = wj1(NOP, 5'h03, 8'h7F);                   // R10 call, R3 wrap after
    mem[10'h000] = w4(5'h10, 5'h04, NOP, NOP);               // R7 restart loop
    mem[10'h001] = wj0(5'h05, 10'h0B0);
    mem[10'h002] = wj0(5'h02, 10'h0B0);
    mem[10'h0B0] = wj2(NOP, NOP, 5'h05, 3'd5);
    mem[10'h0B1] = wj1(NOP, 5'h06, 8'h10);                   // R9 zero test
    mem[10'h010] = wj0(5'h03, 10'h0B2);
    mem[10'h0B2] = wj0(5'h07, 10'h2B4) | 18'h01C00;          // R5 ignored bits set
    mem[10'h2B4] = wj0(5'h02, 10'h0B3);
    mem[10'h0B3] = wj2(5'h13, NOP, 5'h02, 3'd7);             // R5 slot 2 reach
    mem[10'h0B7] = wj0(5'h02, 10'h15D);                      // into I/O space
    mem[10'h15D] = wj1(NOP, 5'h02, 8'h20);                   // R3 no advance, R5 P8 cleared
    mem[10'h020] = w4(5'h00, NOP, NOP, NOP);                 // R6 return
    mem[10'h011] = w4(NOP, 5'h01, NOP, NOP);                 // R6 swap

    rv = 18'd3;
    fetch_ready = 1'b0;
    fetch_word = mem[0];
    t_val = '0;
    r_val = rv;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      #0.5;
      chk(fetch_req == 1'b1, "R1", "fetch_req", 32'(fetch_req), 32'd1);
      chk(fetch_addr == 10'h0AA, "R1", "fetch_addr", 32'(fetch_addr), 32'h0AA);
      chk(op_valid == 1'b0, "R1", "op_valid", 32'(op_valid), 32'd0);
    end
    m_fetch = 1; m_p = 10'h0AA; m_word = '0; m_slot = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      step(c);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule